// File: doc/BRIEF.md
# Core Split Mode Controller

This block decides how an eight-thread processor core is divided into hardware subcores. The core runs in one of three modes: one subcore holding all eight threads, two subcores of four threads each, or four subcores of two threads each. Software drives the block through a small control word. It has a hold bit that stops the core from merging back to one subcore, and two one-shot request bits, one asking for the two-way split and one for the four-way split. Software then reads the two mode status bits to learn which mode is in effect.

Moving between the two split modes in one step is not allowed. A split core goes back to one subcore only through the hardware merge. The merge happens when the hold bit is clear and every thread except thread 0 reports that it is napping. Each change of mode completes a fixed number of cycles after its trigger. During that wait a busy flag is raised and the status bits keep their old values. For every thread the block also gives the index of the subcore the thread belongs to and a mask of that thread's siblings.

Top module: `core_split_ctrl`

## Requirements
- R1: After reset the core is in one subcore, both status bits (`stat_two_o`, `stat_four_o`) are 0, `pdis_o`, `busy_o` and `err_o` are 0, every subcore index is 0 and every sibling mask is all ones.
- R2: Control word bits: bit 0 = hold, bit 1 = two-way request, bit 2 = four-way request. A write with the hold bit and exactly one request bit set, made while the core is in one subcore and not busy, raises `busy_o` from the next cycle for SETTLE cycles (default 4). After that `busy_o` drops and the matching status bit is 1.
- R3: While `busy_o` is high, both status bits keep the values they had before the change began.
- R4: A write with both request bits set, or with any request bit set while the core is split or busy, leaves the mode unchanged and sets `err_o`. `err_o` then stays 1 until reset.
- R5: A request bit written without the hold bit, while the core is in one subcore and idle, is ignored: no busy phase, no mode change, no error.
- R6: The core never moves between the two-way and four-way modes without passing through one subcore.
- R7: When the core is split, `pdis_o` is 0 and nap inputs 1 to 7 are all 1, a merge starts on the next clock edge and both status bits read 0 SETTLE cycles later. The nap input of thread 0 has no effect.
- R8: While `pdis_o` is 1, a split core stays split whatever the nap inputs are.
- R9: If the merge condition stops holding while a merge is busy, the merge is abandoned at the next edge: `busy_o` drops and the split mode is kept.
- R10: Thread t has subcore index t / (8 / n), where n is the number of subcores of the current mode (1, 2 or 4).
- R11: The sibling mask of thread t has (8 / n) low bits set, shifted left by the first thread of t's subcore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 3 | Control word: bit 0 hold, bit 1 two-way request, bit 2 four-way request |
| nap_i | input | NTHREADS | Per-thread nap indication |
| pdis_o | output | 1 | Current hold bit |
| stat_two_o | output | 1 | Two-way split in effect |
| stat_four_o | output | 1 | Four-way split in effect |
| busy_o | output | 1 | Mode change in progress |
| err_o | output | 1 | Sticky flag for a rejected request |
| sub_idx_o | output | NTHREADS*2 | Subcore index per thread, thread t at bits [2t+1:2t] |
| sib_mask_o | output | NTHREADS*NTHREADS | Sibling mask per thread, thread t at bits [8t+7:8t] |

## Verification
The assertions assume the inputs are clean and synchronous to `clk`. They also assume that a request arrives as a single one-cycle write strobe. They make no assumption about nap timing, because the merge guard accepts any pattern.

The stimulus changes inputs only on the falling edge and raises `ctrl_we` for exactly one cycle per write. It changes nap inputs only while the core is idle, except in the one case where it deliberately breaks a merge that is already running.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_TWO  = 2'd1,
    MODE_FOUR = 2'd2
  } split_mode_e;

  localparam int unsigned CTRL_W   = 3;
  localparam int unsigned BIT_HOLD = 0;
  localparam int unsigned BIT_REQ2 = 1;
  localparam int unsigned BIT_REQ4 = 2;
endpackage

// File: rtl/csc_req_check.sv
module csc_req_check
  import csc_pkg::*;
(
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  split_mode_e       mode,
  input  logic              busy,
  output logic              split_start,
  output split_mode_e       split_tgt,
  output logic              err_evt
);
  logic want2, want4, any_req, both_req, idle_one;

  always_comb begin
    want2       = ctrl_wdata[BIT_REQ2];
    want4       = ctrl_wdata[BIT_REQ4];
    any_req     = ctrl_we && (want2 || want4);
    both_req    = want2 && want4;
    idle_one    = (mode == MODE_ONE) && !busy;
    split_start = any_req && !both_req && idle_one && ctrl_wdata[BIT_HOLD];
    split_tgt   = want4 ? MODE_FOUR : MODE_TWO;
    err_evt     = any_req && (both_req || !idle_one);
  end
endmodule

// File: rtl/csc_mode_fsm.sv
module csc_mode_fsm
  import csc_pkg::*;
#(
  parameter int unsigned NTHREADS = 8,
  parameter int unsigned SETTLE   = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic [NTHREADS-1:0] nap_i,
  input  logic              split_start,
  input  split_mode_e       split_tgt,
  input  logic              err_evt,
  output split_mode_e       mode_q,
  output logic              pdis_q,
  output logic              busy_q,
  output logic              err_q,
  output logic              unsplit_start,
  output logic              unsplit_abort,
  output logic              commit
);
  localparam int unsigned CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LOAD = CW'(SETTLE - 1);
  localparam logic [NTHREADS-1:0] T0_BIT = NTHREADS'(1);

  logic [CW-1:0] cnt_q;
  split_mode_e   tgt_q;
  logic          others_nap, merge_ok;

  always_comb begin
    others_nap    = &(nap_i | T0_BIT);
    merge_ok      = (mode_q != MODE_ONE) && !pdis_q && others_nap;
    unsplit_start = !busy_q && merge_ok;
    unsplit_abort = busy_q && (tgt_q == MODE_ONE) && !merge_ok;
    commit        = busy_q && !unsplit_abort && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdis_q <= 1'b0;
      mode_q <= MODE_ONE;
      tgt_q  <= MODE_ONE;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_we) pdis_q <= ctrl_wdata[BIT_HOLD];
      if (err_evt) err_q <= 1'b1;
      if (!busy_q) begin
        if (split_start) begin
          busy_q <= 1'b1;
          cnt_q  <= LOAD;
          tgt_q  <= split_tgt;
        end else if (unsplit_start) begin
          busy_q <= 1'b1;
          cnt_q  <= LOAD;
          tgt_q  <= MODE_ONE;
        end
      end else if (unsplit_abort) begin
        busy_q <= 1'b0;
      end else if (commit) begin
        mode_q <= tgt_q;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/csc_thread_map.sv
module csc_thread_map
  import csc_pkg::*;
#(
  parameter int unsigned NTHREADS = 8,
  parameter int unsigned SUBW     = 2
)(
  input  split_mode_e                    mode,
  output logic [NTHREADS*SUBW-1:0]       sub_idx_o,
  output logic [NTHREADS*NTHREADS-1:0]   sib_mask_o
);
  function automatic int unsigned group_size(split_mode_e m);
    case (m)
      MODE_TWO:  return NTHREADS / 2;
      MODE_FOUR: return NTHREADS / 4;
      default:   return NTHREADS;
    endcase
  endfunction

  function automatic logic [SUBW-1:0] sub_of(int unsigned tid, split_mode_e m);
    return SUBW'(tid / group_size(m));
  endfunction

  function automatic logic [NTHREADS-1:0] mask_of(int unsigned tid, split_mode_e m);
    int unsigned gs;
    logic [NTHREADS-1:0] ones;
    gs   = group_size(m);
    ones = {NTHREADS{1'b1}} >> (NTHREADS - gs);
    return ones << ((tid / gs) * gs);
  endfunction

  for (genvar g = 0; g < NTHREADS; g++) begin : g_thr
    assign sub_idx_o[g*SUBW +: SUBW]         = sub_of(g, mode);
    assign sib_mask_o[g*NTHREADS +: NTHREADS] = mask_of(g, mode);
  end
endmodule

// File: rtl/core_split_ctrl.sv
module core_split_ctrl
  import csc_pkg::*;
#(
  parameter int unsigned NTHREADS = 8,
  parameter int unsigned SETTLE   = 4
)(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ctrl_we,
  input  logic [2:0]                     ctrl_wdata,
  input  logic [NTHREADS-1:0]            nap_i,
  output logic                           pdis_o,
  output logic                           stat_two_o,
  output logic                           stat_four_o,
  output logic                           busy_o,
  output logic                           err_o,
  output logic [NTHREADS*2-1:0]          sub_idx_o,
  output logic [NTHREADS*NTHREADS-1:0]   sib_mask_o
);
  localparam int unsigned SUBW = 2;

  split_mode_e mode_q, split_tgt;
  logic split_start, err_evt, unsplit_start, unsplit_abort, commit;

  csc_req_check u_req (
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .mode        (mode_q),
    .busy        (busy_o),
    .split_start (split_start),
    .split_tgt   (split_tgt),
    .err_evt     (err_evt)
  );

  csc_mode_fsm #(.NTHREADS(NTHREADS), .SETTLE(SETTLE)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_we       (ctrl_we),
    .ctrl_wdata    (ctrl_wdata),
    .nap_i         (nap_i),
    .split_start   (split_start),
    .split_tgt     (split_tgt),
    .err_evt       (err_evt),
    .mode_q        (mode_q),
    .pdis_q        (pdis_o),
    .busy_q        (busy_o),
    .err_q         (err_o),
    .unsplit_start (unsplit_start),
    .unsplit_abort (unsplit_abort),
    .commit        (commit)
  );

  csc_thread_map #(.NTHREADS(NTHREADS), .SUBW(SUBW)) u_map (
    .mode       (mode_q),
    .sub_idx_o  (sub_idx_o),
    .sib_mask_o (sib_mask_o)
  );

  assign stat_two_o  = (mode_q == MODE_TWO);
  assign stat_four_o = (mode_q == MODE_FOUR);
endmodule

// File: rtl/core_split_ctrl_chk.sv
module core_split_ctrl_chk #(
  parameter int unsigned NTHREADS = 8
)(
  input logic                clk,
  input logic                rst_n,
  input logic                pdis,
  input logic                stat_two,
  input logic                stat_four,
  input logic                busy,
  input logic                err,
  input logic                commit,
  input logic [NTHREADS-1:0] nap
);
  logic split;
  assign split = stat_two || stat_four;

  a_r1_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_two, stat_four}));

  a_r2_rise_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(split) |-> $past(busy));

  a_r3_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable({stat_two, stat_four})));

  a_r3_change_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({stat_two, stat_four}));

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r6_no_two_to_four: assert property (@(posedge clk) disable iff (!rst_n)
    stat_two |=> !stat_four);

  a_r6_no_four_to_two: assert property (@(posedge clk) disable iff (!rst_n)
    stat_four |=> !stat_two);

  a_r7_merge_cause: assert property (@(posedge clk) disable iff (!rst_n)
    split |=> (split || ($past(!pdis) && $past(&nap[NTHREADS-1:1]))));

  a_r8_hold_keeps_split: assert property (@(posedge clk) disable iff (!rst_n)
    (split && pdis) |=> split);
endmodule

bind core_split_ctrl core_split_ctrl_chk #(.NTHREADS(NTHREADS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pdis      (pdis_o),
  .stat_two  (stat_two_o),
  .stat_four (stat_four_o),
  .busy      (busy_o),
  .err       (err_o),
  .commit    (commit),
  .nap       (nap_i)
);

// File: tb/core_split_ctrl_tb.sv
`timescale 1ns/1ps
module core_split_ctrl_tb;
  localparam int NT = 8;
  localparam int ST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [2:0] ctrl_wdata = '0;
  logic [NT-1:0] nap_i = '0;
  logic pdis_o, stat_two_o, stat_four_o, busy_o, err_o;
  logic [NT*2-1:0] sub_idx_o;
  logic [NT*NT-1:0] sib_mask_o;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  core_split_ctrl #(.NTHREADS(NT), .SETTLE(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .nap_i(nap_i), .pdis_o(pdis_o), .stat_two_o(stat_two_o),
    .stat_four_o(stat_four_o), .busy_o(busy_o), .err_o(err_o),
    .sub_idx_o(sub_idx_o), .sib_mask_o(sib_mask_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; nap_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] v);
    ctrl_wdata = v; ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // busy must read 1 for nbusy sampled negedges (starting now), status fixed, then final
  task automatic expect_trans(input int nbusy, input logic [1:0] old_st, input logic [1:0] new_st);
    for (int i = 0; i < nbusy; i++) begin
      chk("R2 busy during change", busy_o, 1);
      chk("R3 status held while busy", {stat_four_o, stat_two_o}, old_st);
      @(negedge clk);
    end
    chk("R2 busy cleared", busy_o, 0);
    chk("R2/R7 final status", {stat_four_o, stat_two_o}, new_st);
  endtask

  task automatic check_map(input int nsub);
    int gs;
    gs = NT / nsub;
    for (int t = 0; t < NT; t++) begin
      logic [NT-1:0] m;
      for (int j = 0; j < NT; j++) m[j] = ((j / gs) == (t / gs));
      chk($sformatf("R10 subcore index t=%0d n=%0d", t, nsub), sub_idx_o[t*2 +: 2], t / gs);
      chk($sformatf("R11 sibling mask t=%0d n=%0d", t, nsub), sib_mask_o[t*NT +: NT], m);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 status after reset", {stat_four_o, stat_two_o}, 0);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 err after reset", err_o, 0);
    chk("R1 hold after reset", pdis_o, 0);
    check_map(1);

    // R5: request without hold
    wr(3'b010);
    repeat (ST + 1) begin
      chk("R5 no busy", busy_o, 0);
      @(negedge clk);
    end
    chk("R5 mode unchanged", {stat_four_o, stat_two_o}, 0);
    chk("R5 no error", err_o, 0);

    // R2: split two
    wr(3'b011);
    expect_trans(ST, 2'b00, 2'b01);
    chk("R2 err still clear", err_o, 0);
    check_map(2);

    // R4 / R6: four-way request while two-way
    wr(3'b101);
    chk("R6 no busy on cross request", busy_o, 0);
    chk("R4 err set", err_o, 1);
    repeat (ST + 2) @(negedge clk);
    chk("R6 still two-way", {stat_four_o, stat_two_o}, 2'b01);

    // R8: hold set, all others napping, thread 0 awake
    nap_i = 8'hFE;
    repeat (ST + 4) begin
      @(negedge clk);
      chk("R8 no busy while hold", busy_o, 0);
    end
    chk("R8 still split", {stat_four_o, stat_two_o}, 2'b01);

    // R7: clear hold -> merge; thread 0 nap is 0
    wr(3'b000);
    chk("R7 not busy before hold seen", busy_o, 0);
    @(negedge clk);
    expect_trans(ST, 2'b01, 2'b00);
    chk("R4 err sticky", err_o, 1);
    check_map(1);

    // R4: both request bits
    do_reset();
    wr(3'b111);
    chk("R4 both bits no busy", busy_o, 0);
    chk("R4 both bits err", err_o, 1);
    repeat (ST) @(negedge clk);
    chk("R4 both bits mode", {stat_four_o, stat_two_o}, 0);

    // R2 four-way with a request during busy (R4)
    do_reset();
    wr(3'b101);
    wr(3'b011);
    chk("R4 err on request while busy", err_o, 1);
    expect_trans(ST - 1, 2'b00, 2'b10);
    check_map(4);

    // R9: abort a merge
    nap_i = 8'hFE;
    wr(3'b000);
    @(negedge clk);
    chk("R9 merge busy", busy_o, 1);
    nap_i = 8'hDE;
    @(negedge clk);
    chk("R9 abort busy low", busy_o, 0);
    chk("R9 mode kept", {stat_four_o, stat_two_o}, 2'b10);
    repeat (ST + 1) @(negedge clk);
    chk("R9 still four-way", {stat_four_o, stat_two_o}, 2'b10);
    nap_i = 8'hFF;
    @(negedge clk);
    expect_trans(ST, 2'b10, 2'b00);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule